// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Lock

This block guards a system against runaway software. A down-counter runs from a programmable reload value once software enables it. When the counter first expires, the block raises an interrupt, which gives software a chance to recover. Each expiry also reloads the counter from the reload value. If the counter expires a second time while that interrupt is still uncleared, and reset generation was enabled, the block asserts a reset request. That request stays high until a hardware reset.

Software reaches the block through a simple single-cycle register port. A write is taken on the clock edge where valid and write are both high. Reads return data combinationally. Once the watchdog is enabled, its control settings are frozen until hardware reset. A lock register guards the remaining registers: any write to it shuts off changes to the reload, control and clear registers, and only one fixed key value opens them again.

Top module: `wdt_top`

## Requirements
- R1: After reset the counter and the reload register both hold all ones, the timer is stopped, the interrupt and reset outputs are low, and the block is unlocked.
- R2: Word addresses are as follows: 0 is the reload value, 1 is the live counter (read-only), 2 is control (bit 0 enables the timer and interrupt, bit 1 enables reset), 3 is interrupt clear (write-only), 4 is raw status (bit 0), 5 is masked status (bit 0) and 6 is lock. Reads of any other address return 0.
- R3: Enabling the timer preloads the counter from the reload value. The counter then drops by one each cycle. On the edge where it would leave zero, which is reload+1 cycles after the enabling edge, it reloads and the interrupt becomes pending.
- R4: If an expiry happens while the interrupt is pending and reset-enable is set, the reset output rises on that edge. It then stays high, even after a later clear, until hardware reset.
- R5: If an expiry happens while the interrupt is pending and reset-enable is clear, the counter reloads, the interrupt stays pending and no reset is requested.
- R6: A write of any value to the clear register clears the pending interrupt and reloads the counter from the reload value on the same edge.
- R7: A write to the reload register updates both the reload value and the counter on the same edge, and counting continues from the new value.
- R8: Writing zero to the reload register makes the interrupt pending on the same edge.
- R9: Once the enable bit is set, every later write to control is ignored until hardware reset.
- R10: A write of 0x1ACCE551 to the lock register unlocks the block, and a write of any other value locks it. Reading the lock register returns 1 when locked and 0 when unlocked. While locked, writes to the reload, control and clear registers have no effect.
- R11: Masked status equals raw status ANDed with the enable bit, and the interrupt output follows masked status.
- R12: Reading address 1 returns the counter value as it stands in the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busValid | input | 1 | Access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt (masked status) |
| rstReq | output | 1 | Sticky system reset request |

## Verification
Writes take effect on the edge that accepts them. Status, counter and output changes from a write can therefore be seen right after that edge. An expiry falls exactly reload+1 edges after the enabling edge, or after the last reload. The bench counts edges from each accepting write and samples one time unit after an edge, so it sees the cycle just before each expiry and the cycle just after it. Reads have no side effects, so a read is checked combinationally within the cycle it is issued.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // register word offsets
  localparam int OFS_LOAD  = 0;
  localparam int OFS_VALUE = 1;
  localparam int OFS_CTRL  = 2;
  localparam int OFS_CLEAR = 3;
  localparam int OFS_RAW   = 4;
  localparam int OFS_MASK  = 5;
  localparam int OFS_LOCK  = 6;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic wrLoad;  // take new reload value into both registers
    logic reload;  // copy reload value into counter
    logic run;     // count down
  } cntStrobe_t;
endpackage

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] loadVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '1;
      loadQ <= '1;
    end else if (strb.wrLoad) begin
      cntQ  <= wrData;
      loadQ <= wrData;
    end else if (strb.reload) begin
      cntQ  <= loadQ;
    end else if (strb.run && (cntQ != '0)) begin
      cntQ  <= cntQ - 1'b1;
    end
  end

  assign cntVal  = cntQ;
  assign loadVal = loadQ;
  assign cntZero = (cntQ == '0);

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.reload && !strb.wrLoad && cntQ != '0) |=> cntQ == $past(cntQ) - 1'b1);

  // R6
  reload_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reload && !strb.wrLoad) |=> cntQ == $past(loadQ));

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLoad |=> $stable(loadQ));
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              cntZero,
  output cntStrobe_t        strb,
  output logic              irq,
  output logic              rstReq
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFS_LOCK);
  localparam logic [CNT_W-1:0]  KEY     = CNT_W'(UNLOCK_KEY);

  logic intEn, rstEnR, locked, irqPend, rstQ;
  logic wrAcc, wrOpen, wrLoad, wrClear, wrCtrl, wrLock, timeout;

  assign wrAcc   = busValid && busWrite;
  assign wrOpen  = wrAcc && !locked;
  assign wrLoad  = wrOpen && (busAddr == A_LOAD);
  assign wrClear = wrOpen && (busAddr == A_CLEAR);
  assign wrCtrl  = wrOpen && (busAddr == A_CTRL) && !intEn;
  assign wrLock  = wrAcc && (busAddr == A_LOCK);
  assign timeout = intEn && cntZero && !wrLoad && !wrClear;

  always_comb begin
    strb.wrLoad = wrLoad;
    strb.reload = wrClear || timeout || (wrCtrl && busWdata[0]);
    strb.run    = intEn;
  end

  // control settings, write-once after enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn  <= 1'b0;
      rstEnR <= 1'b0;
    end else if (wrCtrl) begin
      intEn  <= busWdata[0];
      rstEnR <= busWdata[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       locked <= 1'b0;
    else if (wrLock) locked <= (busWdata != KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  irqPend <= 1'b0;
    else if (wrClear)                           irqPend <= 1'b0;
    else if (timeout || (wrLoad && busWdata == '0)) irqPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            rstQ <= 1'b0;
    else if (timeout && irqPend && rstEnR) rstQ <= 1'b1;
  end

  assign irq    = irqPend && intEn;
  assign rstReq = rstQ;

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      unique case (busAddr)
        A_LOAD:  busRdata = loadVal;
        A_VALUE: busRdata = cntVal;
        A_CTRL:  busRdata = CNT_W'({rstEnR, intEn});
        A_RAW:   busRdata = CNT_W'(irqPend);
        A_MASK:  busRdata = CNT_W'(irqPend && intEn);
        A_LOCK:  busRdata = CNT_W'(locked);
        default: busRdata = '0;
      endcase
    end
  end

  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstQ |=> rstQ);

  // R4
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstQ) |-> ($past(irqPend) && $past(rstEnR) && $past(cntZero)));

  // R9
  ctrl_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEn |=> (intEn && $stable(rstEnR)));

  // R10
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrAcc && busAddr != A_LOCK) |=> ($stable(loadVal) && $stable(intEn)));

  // R3
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> ($past(cntZero && intEn) || $past(wrLoad)));
endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irq,
  output logic              rstReq
);
  cntStrobe_t       strb;
  logic [CNT_W-1:0] cntVal, loadVal;
  logic             cntZero;

  wdt_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .loadVal(loadVal), .cntZero(cntZero),
    .strb(strb), .irq(irq), .rstReq(rstReq)
  );

  wdt_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .cntVal(cntVal), .loadVal(loadVal), .cntZero(cntZero)
  );
endmodule

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam logic [2:0] A_LOAD = 3'd0, A_VALUE = 3'd1, A_CTRL = 3'd2,
                         A_CLEAR = 3'd3, A_RAW = 3'd4, A_MASK = 3'd5, A_LOCK = 3'd6;
  localparam logic [1:0] OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;   // write data or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR, A_LOAD,  32'd10, 8'd7},   // R7
    '{OP_RD, A_VALUE, 32'd10, 8'd7},   // R7 counter follows reload write
    '{OP_RD, A_LOAD,  32'd10, 8'd2},   // R2
    '{OP_WR, A_CTRL,  32'd2,  8'd9},   // R9 reset-enable only, timer stays stopped
    '{OP_RD, A_CTRL,  32'd2,  8'd2},   // R2
    '{OP_WR, A_LOCK,  32'd0,  8'd10},  // R10 lock
    '{OP_RD, A_LOCK,  32'd1,  8'd10},  // R10
    '{OP_WR, A_LOAD,  32'd3,  8'd10},  // R10 dropped
    '{OP_RD, A_LOAD,  32'd10, 8'd10},  // R10
    '{OP_WR, A_LOCK,  KEY,    8'd10},  // R10 unlock
    '{OP_RD, A_LOCK,  32'd0,  8'd10},  // R10
    '{OP_WR, A_CTRL,  32'd3,  8'd3},   // R3 enable, preload
    '{OP_RD, A_VALUE, 32'd10, 8'd3},   // R3
    '{OP_RD, A_VALUE, 32'd9,  8'd12},  // R12
    '{OP_WR, A_CTRL,  32'd0,  8'd9},   // R9 ignored
    '{OP_RD, A_CTRL,  32'd3,  8'd9},   // R9
    '{OP_RD, A_VALUE, 32'd6,  8'd12}   // R12
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, rstReq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wdt_top dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .rstReq(rstReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic doRst();
    busValid = 1'b0; busWrite = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    doRst();
    // R1 reset state
    rd(A_VALUE, v); check("R1 counter", v, 32'hFFFF_FFFF);
    rd(A_LOAD, v);  check("R1 reload", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  check("R1 control", v, 0);
    rd(A_LOCK, v);  check("R1 lock", v, 0);
    check("R1 irq", irq, 0);
    check("R1 rstReq", rstReq, 0);
    rd(3'd7, v);    check("R2 unused addr", v, 0);

    // vector table, one edge per entry
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].op == OP_WR) begin
        wr(VEC[i].addr, VEC[i].data);
      end else begin
        busValid = 1'b1; busWrite = 1'b0; busAddr = VEC[i].addr;
        #1;
        checks++;
        if (busRdata !== VEC[i].data) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].req, i, busRdata, VEC[i].data);
        end
        @(posedge clk);
        #1;
        busValid = 1'b0;
      end
    end

    // R3 / R5 / R6 / R11 / R12: reload 4, interrupt only
    doRst();
    wr(A_LOAD, 32'd4);
    wr(A_CTRL, 32'd1);
    tick(4);
    check("R3 no irq before expiry", irq, 0);
    rd(A_VALUE, v); check("R3 counter at zero", v, 0);
    tick(1);
    check("R3 irq at first expiry", irq, 1);
    rd(A_RAW, v);   check("R11 raw", v, 1);
    rd(A_MASK, v);  check("R11 masked", v, 1);
    rd(A_VALUE, v); check("R3 reload after expiry", v, 4);
    tick(5);
    check("R5 no reset", rstReq, 0);
    check("R5 irq held", irq, 1);
    rd(A_VALUE, v); check("R5 reload on second expiry", v, 4);
    wr(A_CLEAR, 32'h55);
    check("R6 irq cleared", irq, 0);
    rd(A_VALUE, v); check("R6 counter reloaded", v, 4);
    tick(2);
    rd(A_VALUE, v); check("R12 live count", v, 2);

    // R4: reload 3, reset enabled
    doRst();
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'd3);
    tick(4);
    check("R4 irq first expiry", irq, 1);
    check("R4 no reset yet", rstReq, 0);
    tick(3);
    check("R4 no reset before second expiry", rstReq, 0);
    tick(1);
    check("R4 reset at second expiry", rstReq, 1);
    wr(A_CLEAR, 32'd0);
    check("R4 irq cleared", irq, 0);
    check("R4 reset sticky", rstReq, 1);

    // R7: reload write while counting
    doRst();
    wr(A_LOAD, 32'd8);
    wr(A_CTRL, 32'd1);
    tick(2);
    rd(A_VALUE, v); check("R7 count before write", v, 6);
    wr(A_LOAD, 32'd20);
    rd(A_VALUE, v); check("R7 counter takes new value", v, 20);
    rd(A_LOAD, v);  check("R7 reload takes new value", v, 20);
    tick(1);
    rd(A_VALUE, v); check("R7 continues counting", v, 19);

    // R8 / R11: zero reload with timer stopped
    doRst();
    wr(A_LOAD, 32'd0);
    rd(A_RAW, v);  check("R8 pending on zero write", v, 1);
    rd(A_MASK, v); check("R11 masked off while disabled", v, 0);
    check("R11 irq low while disabled", irq, 0);

    // R10: locked block drops clear and control writes
    doRst();
    wr(A_LOAD, 32'd0);
    wr(A_LOCK, 32'd7);
    wr(A_CLEAR, 32'd0);
    rd(A_RAW, v);  check("R10 clear dropped", v, 1);
    wr(A_CTRL, 32'd1);
    rd(A_CTRL, v); check("R10 control dropped", v, 0);
    wr(A_LOCK, KEY);
    wr(A_CLEAR, 32'd0);
    rd(A_RAW, v);  check("R10 clear after unlock", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule